// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives a packet transmitter from a ring of two-word descriptors held in memory. A descriptor's first word is a buffer address. Its second word is a control word that carries a fragment length, an end-of-packet flag, a ring-wrap flag and an ownership flag. After a start strobe the walker reads descriptors through a single request/acknowledge memory port. It presents each buffer fragment on a valid/ready output. When the last fragment of a packet has been accepted, it writes a completion word back to the first descriptor of that packet.

Ownership is checked only where a packet begins. If the descriptor at a packet start is owned, the walker halts there. On the next start it resumes from that same position and does not go back to the ring base. Descriptors that continue a packet are fetched and sent whatever their ownership bit says, and they are never written. Software therefore keeps the walker from running ahead by marking the slot after its newest packet as owned. The per-packet status arrives as an input and is copied into the write-back word.

Top module: `txdesc_walker`

## Requirements
- R1: A fragment shows word 0 of its descriptor on `frag_addr`, control bits [13:0] on `frag_len` and control bit 15 (end of packet) on `frag_eop`. These values stay stable while `frag_valid` is high and `frag_ready` is low.
- R2: When the descriptor at a packet start has control bit 31 (owned) set, no fragment is sent, the memory port goes quiet and `idle` goes high.
- R3: A descriptor that continues a packet is sent even when its bit 31 is set, and the walker never writes it.
- R4: After the end-of-packet fragment is accepted, exactly one write goes to the control word (byte offset +4) of the packet's first descriptor. The value is bit 31 = 1, bit 30 and bit 15 kept, bits [29:16] = `pkt_status`, bit 14 = 0 and bits [13:0] kept. `pkt_done` pulses for one cycle after that write.
- R5: A start resumes at the descriptor after the last one processed. It does not restart at the ring base.
- R6: The next descriptor lies 8 bytes further on. After a descriptor with control bit 30 (wrap) set, the next descriptor is at `RING_BASE`.
- R7: A start that arrives while the walker is busy is held. When the walker then meets an owned packet start, it reads that control word once more before it halts.
- R8: A fetched descriptor with zero length sets the sticky `err`. The walker stops with `idle` low and sends nothing from that descriptor. It writes nothing back, and it ignores further starts until reset.
- R9: A descriptor with wrap set and end of packet clear also sets `err` and aborts the packet. Fragments already sent stay sent, and the packet's first descriptor gets no write-back.
- R10: During and right after reset, `frag_valid`, `mem_req`, `pkt_done`, `idle` and `err` are all low, and the first fetch reads the descriptor at `RING_BASE`.
- R11: A memory request holds its address, direction and write data until it is acknowledged. Every address is word aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start strobe |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| frag_valid | output | 1 | Fragment on offer |
| frag_ready | input | 1 | Transmitter accepts the fragment |
| frag_addr | output | AW | Fragment buffer address |
| frag_len | output | 14 | Fragment length in bytes |
| frag_eop | output | 1 | Fragment ends its packet |
| pkt_status | input | 14 | Status copied into the write-back word |
| pkt_done | output | 1 | One-cycle pulse per completed packet |
| idle | output | 1 | Halted at an owned packet start |
| err | output | 1 | Sticky descriptor error |

## Verification
The bench places an owned bit on a continuation descriptor. A walker that tests ownership on every fetch would drop that fragment, and one that writes back every descriptor would change its control word. A second start is sent while the walker sits on a stalled fragment, and a trapped memory read clears the stopper descriptor right after its first read. A walker that does not hold the start would halt and lose the final packet. A wrap test checks that the next fetch lands on the ring base and not past the ring end. Separate runs use a zero-length descriptor and a wrap without end of packet, which must set the error with no write-back, where a faulty design would send garbage or mark the packet done.

// File: rtl/txdesc_walker.sv
module txdesc_walker #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RING_BASE = 'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          frag_valid,
  input  logic          frag_ready,
  output logic [AW-1:0] frag_addr,
  output logic [13:0]   frag_len,
  output logic          frag_eop,
  input  logic [13:0]   pkt_status,
  output logic          pkt_done,
  output logic          idle,
  output logic          err
);
  localparam int LEN_W  = 14;
  localparam int B_LAST = 15;
  localparam int B_WRAP = 30;
  localparam int B_OWN  = 31;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_SEND, S_WB} st_t;
  st_t st;

  logic [AW-1:0]    cur, first, baddr;
  logic [LEN_W-1:0] c_len, f_len;
  logic             c_last, c_wrap, f_last, f_wrap;
  logic             head, pend, halted, err_q, done_q;

  wire              ack  = mem_req & mem_ack;
  wire [AW-1:0]     nxt  = c_wrap ? RING_BASE : cur + AW'(8);
  wire [LEN_W-1:0]  r_len = mem_rdata[LEN_W-1:0];
  wire              r_own = mem_rdata[B_OWN];
  wire              r_last = mem_rdata[B_LAST];
  wire              r_wrap = mem_rdata[B_WRAP];
  wire              unused_bits = ^{mem_rdata[29:16], mem_rdata[14]};

  assign mem_req    = (st == S_CTRL) | (st == S_ADDR) | (st == S_WB);
  assign mem_we     = (st == S_WB);
  assign mem_addr   = (st == S_WB) ? first + AW'(4) : (st == S_CTRL) ? cur + AW'(4) : cur;
  assign mem_wdata  = {1'b1, f_wrap, pkt_status, f_last, 1'b0, f_len};
  assign frag_valid = (st == S_SEND);
  assign frag_addr  = baddr;
  assign frag_len   = c_len;
  assign frag_eop   = c_last;
  assign pkt_done   = done_q;
  assign idle       = halted;
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= RING_BASE;
      first <= RING_BASE;
      baddr <= '0;
      c_len <= '0; c_last <= 1'b0; c_wrap <= 1'b0;
      f_len <= '0; f_last <= 1'b0; f_wrap <= 1'b0;
      head <= 1'b1;
      pend <= 1'b0;
      halted <= 1'b0;
      err_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && st != S_IDLE) pend <= 1'b1;
      case (st)
        S_IDLE: if (start && !err_q) begin
          st <= S_CTRL;
          halted <= 1'b0;
          head <= 1'b1;
        end
        S_CTRL: if (ack) begin
          c_len <= r_len; c_last <= r_last; c_wrap <= r_wrap;
          if (head && r_own) begin
            if (pend || start) pend <= pend & start;
            else begin
              st <= S_IDLE;
              halted <= 1'b1;
            end
          end else if (r_len == '0 || (r_wrap && !r_last)) begin
            err_q <= 1'b1;
            pend <= 1'b0;
            st <= S_IDLE;
          end else begin
            st <= S_ADDR;
            if (head) begin
              first <= cur;
              f_len <= r_len; f_last <= r_last; f_wrap <= r_wrap;
            end
          end
        end
        S_ADDR: if (ack) begin
          baddr <= mem_rdata[AW-1:0];
          st <= S_SEND;
        end
        S_SEND: if (frag_ready) begin
          cur <= nxt;
          head <= c_last;
          st <= c_last ? S_WB : S_CTRL;
        end
        S_WB: if (ack) begin
          done_q <= 1'b1;
          st <= S_CTRL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module txdesc_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          frag_valid,
  input logic          frag_ready,
  input logic [AW-1:0] frag_addr,
  input logic [13:0]   frag_len,
  input logic          frag_eop,
  input logic          pkt_done,
  input logic          idle,
  input logic          err
);
  p_frag_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid && !frag_ready |=> frag_valid && $stable(frag_addr) && $stable(frag_len) && $stable(frag_eop));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !frag_valid && !mem_req);
  p_wb_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[31] && mem_wdata[14] == 1'b0);
  p_done_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> $past(mem_req && mem_we && mem_ack));
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_req && !frag_valid && !idle);
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_mem_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

bind txdesc_walker txdesc_walker_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_txdesc_walker.sv
module sim_txdesc_walker;
  localparam logic [31:0] BASE = 32'h1000;
  localparam logic [31:0] OWN = 32'h8000_0000, WRP = 32'h4000_0000, LST = 32'h0000_8000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic mem_req, mem_we, mem_ack, frag_valid, frag_ready, frag_eop, pkt_done, idle, err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, frag_addr;
  logic [13:0] frag_len;
  logic [13:0] pkt_status = 14'h12A5;

  always #4 clk = ~clk;

  txdesc_walker u0 (.*);

  logic [31:0] mem [0:63];
  logic [7:0] tick = 8'd0;
  logic stall_on = 1'b0, bp_on = 1'b0, rdy_block = 1'b0;
  logic hw_we = 1'b0; logic [5:0] hw_idx = 6'd0; logic [31:0] hw_val = 32'd0;
  logic trap_arm = 1'b0, trap_fired = 1'b0; logic [5:0] trap_idx = 6'd0; logic [31:0] trap_val = 32'd0;

  assign mem_ack    = mem_req & (stall_on ? tick[0] : 1'b1);
  assign mem_rdata  = mem[mem_addr[7:2]];
  assign frag_ready = rdy_block ? 1'b0 : (bp_on ? (tick[1:0] != 2'b00) : 1'b1);

  always @(posedge clk) begin
    tick <= tick + 8'd1;
    if (hw_we) mem[hw_idx] <= hw_val;
    if (mem_req && mem_ack && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (trap_arm && !trap_fired && mem_req && mem_ack && !mem_we && mem_addr[7:2] == trap_idx) begin
      mem[trap_idx] <= trap_val;
      trap_fired <= 1'b1;
    end
  end

  int checks = 0, bad = 0, done_seen = 0, frags_seen = 0;
  logic [46:0] exp_q [$];

  always @(negedge clk) begin
    if (pkt_done) done_seen++;
    if (frag_valid && frag_ready) begin
      frags_seen++;
      checks++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected fragment: actual %h/%0d/%b expected none", frag_addr, frag_len, frag_eop);
      end else begin
        logic [46:0] e;
        e = exp_q.pop_front();
        if ({frag_addr, frag_len, frag_eop} !== e) begin
          bad++;
          $display("FAIL R1 fragment: actual %h/%0d/%b expected %h/%0d/%b",
                   frag_addr, frag_len, frag_eop, e[46:15], e[14:1], e[0]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [31:0] v);
    @(negedge clk); hw_we = 1'b1; hw_idx = 6'(idx); hw_val = v;
    @(negedge clk); hw_we = 1'b0;
  endtask

  task automatic put_desc(input int k, input logic [31:0] a, input logic [31:0] c);
    put(2*k, a);
    put(2*k+1, c);
  endtask

  task automatic expect_frag(input logic [31:0] a, input int len, input bit eop);
    exp_q.push_back({a, 14'(len), eop});
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_stop;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ((idle || err) && !mem_req) break;
    end
  endtask

  function automatic logic [31:0] wb(input logic [31:0] c);
    return OWN | (c & (WRP | LST | 32'h3FFF)) | (32'(pkt_status) << 16);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!frag_valid && !mem_req && !pkt_done && !idle && !err, "R10 outputs in reset",
          {27'd0, frag_valid, mem_req, pkt_done, idle, err}, 32'd0);
    put_desc(0, 32'hA000_0000, 32'd100);
    put_desc(1, 32'hA000_0100, OWN | LST | 32'd40);
    put_desc(2, 32'hA000_0200, LST | 32'd64);
    put_desc(3, 32'hA000_0300, OWN);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!frag_valid && !mem_req && !idle && !err, "R10 after reset",
          {28'd0, frag_valid, mem_req, idle, err}, 32'd0);

    // R1 R3 R4 R10: two packets, owned continuation, stalls
    stall_on = 1'b1; bp_on = 1'b1;
    expect_frag(32'hA000_0000, 100, 1'b0);
    expect_frag(32'hA000_0100, 40, 1'b1);
    expect_frag(32'hA000_0200, 64, 1'b1);
    pulse_start; wait_stop;
    check(exp_q.size() == 0, "R3 all fragments sent", exp_q.size(), 0);
    check(done_seen == 2, "R4 done pulses", done_seen, 2);
    check(mem[1] == wb(32'd100), "R4 first desc write-back", mem[1], wb(32'd100));
    check(mem[3] == (OWN | LST | 32'd40), "R3 continuation untouched", mem[3], OWN | LST | 32'd40);
    check(mem[5] == wb(LST | 32'd64), "R4 single-frag write-back", mem[5], wb(LST | 32'd64));
    check(idle && mem[7] == OWN, "R2 halted at owned stopper", mem[7], OWN);
    stall_on = 1'b0; bp_on = 1'b0;

    // R5 resume at slot 3
    pkt_status = 14'h0F0F;
    put_desc(4, 32'hA000_0400, OWN);
    put_desc(3, 32'hA000_0300, LST | 32'd20);
    expect_frag(32'hA000_0300, 20, 1'b1);
    pulse_start; wait_stop;
    check(exp_q.size() == 0 && done_seen == 3, "R5 resumed at next descriptor", done_seen, 3);
    check(mem[7] == wb(LST | 32'd20), "R5 write-back slot 3", mem[7], wb(LST | 32'd20));

    // R2 owned start: nothing sent
    begin
      int f0;
      f0 = frags_seen;
      pulse_start; wait_stop;
      check(frags_seen == f0 && done_seen == 3 && idle, "R2 owned start sends nothing", frags_seen, f0);
    end

    // R7 start held while busy; stopper freed after its first read
    rdy_block = 1'b1;
    put_desc(5, 32'hA000_0500, OWN | LST | 32'd12);
    put_desc(6, 32'hA000_0600, OWN);
    put_desc(4, 32'hA000_0400, LST | 32'd10);
    trap_idx = 6'd11; trap_val = LST | 32'd12; trap_arm = 1'b1;
    expect_frag(32'hA000_0400, 10, 1'b1);
    expect_frag(32'hA000_0500, 12, 1'b1);
    pulse_start;
    for (int i = 0; i < 200 && !frag_valid; i++) @(negedge clk);
    pulse_start;
    rdy_block = 1'b0;
    wait_stop;
    check(exp_q.size() == 0 && done_seen == 5, "R7 held start re-check", done_seen, 5);
    check(mem[11] == wb(LST | 32'd12), "R7 recovered packet write-back", mem[11], wb(LST | 32'd12));

    // R6 wrap back to base
    put_desc(7, 32'hA000_0700, WRP | LST | 32'd31);
    put_desc(6, 32'hA000_0600, 32'd30);
    expect_frag(32'hA000_0600, 30, 1'b0);
    expect_frag(32'hA000_0700, 31, 1'b1);
    pulse_start; wait_stop;
    check(exp_q.size() == 0 && done_seen == 6 && idle, "R6 packet across wrap slot", done_seen, 6);
    check(mem[13] == wb(32'd30), "R6 write-back before wrap", mem[13], wb(32'd30));
    put_desc(1, 32'hA000_0100, OWN | LST | 32'd40);
    put_desc(0, 32'hC000_0000, LST | 32'd5);
    expect_frag(32'hC000_0000, 5, 1'b1);
    pulse_start; wait_stop;
    check(exp_q.size() == 0 && done_seen == 7, "R6 next fetch at ring base", done_seen, 7);

    // R8 zero length
    put_desc(1, 32'hD000_0000, LST);
    pulse_start; wait_stop;
    check(err && !idle, "R8 error set, not idle", {30'd0, err, idle}, 32'd2);
    check(done_seen == 7 && mem[3] == LST, "R8 no write-back", mem[3], LST);
    begin
      int reqs = 0;
      pulse_start;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_req || frag_valid) reqs++; end
      check(reqs == 0 && err, "R8 start ignored after error", reqs, 0);
    end

    // R9 wrap without end of packet; R10 reset restart at base
    rst_n = 1'b0;
    put_desc(0, 32'hE000_0000, 32'd8);
    put_desc(1, 32'hE000_0100, WRP | 32'd9);
    @(negedge clk);
    check(!err && !idle, "R10 reset clears error", {30'd0, err, idle}, 32'd0);
    rst_n = 1'b1;
    expect_frag(32'hE000_0000, 8, 1'b0);
    pulse_start; wait_stop;
    check(err && exp_q.size() == 0, "R9 wrap mid-packet error", {31'd0, err}, 32'd1);
    check(mem[1] == 32'd8 && done_seen == 7, "R9 no write-back", mem[1], 32'd8);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule